// File: doc/BRIEF.md
# Sequential Line Prefetch Buffer

This block sits next to a primary instruction cache and holds one cache line fetched ahead of the program counter. Each CPU fetch address is checked against the buffer in the same cycle as the cache lookup. A miss in the cache starts a sequential stream: the block asks a second-level memory port for the line after the missing one. When a later fetch finds that line in the buffer, the line is offered to the cache for a fill. In the normal mode the stream then moves on to the next line. A branch ends the stream.

A combined mode is provided for systems that also have branch-target prefetch buffers. In that mode the next sequential line is requested on any of three events: a true miss, a hit in this buffer, or a hit in a companion buffer. The buffer is always in one of three states: empty, pending or valid. A fetch that matches a line still in flight is reported as pending, so the fetch unit can stall instead of treating it as a miss. Each request carries a small tag. A new trigger makes the outstanding request stale, and any response with a stale tag is discarded.

Top module: `sb_stream_buffer`

## Requirements
- R1: After reset the buffer is empty. No request is presented, and no fetch produces a fill or a pending hit.
- R2: A fetch that misses the I-cache and does not match the buffer line starts a stream. Starting in the normal mode does not depend on the companion hit input. From the next cycle on, a request is presented for the line after the fetched one. That address is the fetch address with its low log2(line bytes) bits cleared, plus the line size, taken modulo 2^ADDR_W.
- R3: A presented request keeps its address and tag unchanged until `l2_req_ready` is high. It is withdrawn in the cycle after it is accepted.
- R4: A response whose tag equals the tag of the accepted request makes the buffer valid. A later fetch in that line that misses the I-cache raises `fill_valid` in the same cycle, with `fill_addr` set to the line address and `fill_data` set to the response data.
- R5: A fetch that misses the I-cache and falls in the line still awaited raises `hit_pending`. It does not raise `fill_valid`, and it leaves the presented request unchanged.
- R6: In the normal mode, a buffer hit while the stream is running requests the following line from the next cycle on.
- R7: A fetch flagged as a branch, with no trigger in the same cycle, stops the stream. An awaited line is dropped, so no request is presented and the line no longer reports pending. A valid line is kept and can still fill, but in the normal mode a hit on it no longer requests the next line.
- R8: In combined mode, two events request the line after the fetched one, even when the stream was stopped: a buffer hit, and a companion-buffer hit on a fetch that misses both the I-cache and this buffer.
- R9: Every new trigger presents a tag different from the previous one. A response carrying an older tag is ignored, and the buffer keeps waiting for its own line.
- R10: In the normal mode, the following fetches leave the buffer unchanged and present no request: a fetch that hits the I-cache, whether or not the companion hit input is high, and a fetch that hits the I-cache inside the buffered line. The second kind also produces no fill.
- R11: A miss that arrives in the same cycle as a branch starts a new stream rather than stopping it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| combined_mode | input | 1 | 1 selects retrigger on buffer and companion hits |
| fetch_valid | input | 1 | A CPU fetch address is present |
| fetch_addr | input | ADDR_W | CPU fetch byte address |
| fetch_branch | input | 1 | The fetched block holds a branch |
| icache_hit | input | 1 | Primary cache hit for this fetch |
| tgt_buf_hit | input | 1 | Hit in a companion branch-target prefetch buffer |
| fill_valid | output | 1 | Buffer hit: line offered for a cache fill |
| fill_addr | output | ADDR_W | Line address of the offered line |
| fill_data | output | LINE_BYTES*8 | Offered line contents |
| hit_pending | output | 1 | Fetch matches the line still in flight |
| l2_req_valid | output | 1 | Request to second-level memory |
| l2_req_ready | input | 1 | Request accepted |
| l2_req_addr | output | ADDR_W | Requested line address |
| l2_req_tag | output | TAG_W | Tag of the current request |
| l2_rsp_valid | input | 1 | Response present |
| l2_rsp_tag | input | TAG_W | Tag returned with the response |
| l2_rsp_data | input | LINE_BYTES*8 | Response line data |

## Verification
A wrong state in the buffer shows at the ports within one or two cycles. A stream that is wrongly stopped or started changes `l2_req_valid` one cycle after the fetch. A wrong line address shows in `l2_req_addr` in that same cycle, and again in `fill_addr` on the next lookup. A stale response taken as current shows up as `fill_valid` where `hit_pending` was expected, or as data that differs from the line that was asked for. The bench sweeps fetch addresses across the address space, including the wrap at the top. After every trigger it compares each request, fill and pending flag with line arithmetic that it computes itself.

// File: rtl/sb_pkg.sv
package sb_pkg;
  typedef enum logic [1:0] {
    SB_EMPTY = 2'd0,
    SB_PEND  = 2'd1,
    SB_VALID = 2'd2
  } sb_state_e;
endpackage

// File: rtl/sb_lookup.sv
module sb_lookup
  import sb_pkg::*;
#(
  parameter int AW    = 16,
  parameter int OFS_W = 5
) (
  input  logic          fetch_valid,
  input  logic [AW-1:0] fetch_addr,
  input  logic          icache_hit,
  input  sb_state_e     buf_state,
  input  logic [AW-1:0] buf_line,
  output logic          line_match,
  output logic          data_hit,
  output logic          pend_hit,
  output logic [AW-1:0] seq_line
);
  localparam logic [AW-1:0] OFS_MASK = AW'((1 << OFS_W) - 1);
  localparam logic [AW-1:0] LINE_INC = AW'(1) << OFS_W;

  // Line base of a byte address.
  function automatic logic [AW-1:0] base_of(input logic [AW-1:0] a);
    return a & ~OFS_MASK;
  endfunction

  // Following line, wrapping modulo 2^AW.
  function automatic logic [AW-1:0] next_of(input logic [AW-1:0] a);
    return base_of(a) + LINE_INC;
  endfunction

  logic [AW-1:0] fetch_line;

  always_comb begin
    fetch_line = base_of(fetch_addr);
    seq_line   = next_of(fetch_addr);
    line_match = fetch_valid && (buf_state != SB_EMPTY) && (buf_line == fetch_line);
    data_hit   = line_match && (buf_state == SB_VALID) && !icache_hit;
    pend_hit   = line_match && (buf_state == SB_PEND) && !icache_hit;
  end
endmodule

// File: rtl/sb_trigger.sv
module sb_trigger (
  input  logic combined_mode,
  input  logic fetch_valid,
  input  logic icache_hit,
  input  logic fetch_branch,
  input  logic tgt_buf_hit,
  input  logic line_match,
  input  logic data_hit,
  input  logic stream_active,
  output logic miss_ev,
  output logic start_ev,
  output logic stop_ev
);
  logic outside;
  logic tgt_ev;
  logic brk_ev;
  logic cont_ev;

  always_comb begin
    outside  = fetch_valid && !icache_hit && !line_match;
    miss_ev  = outside && !(combined_mode && tgt_buf_hit);
    tgt_ev   = outside && combined_mode && tgt_buf_hit;
    brk_ev   = fetch_valid && fetch_branch;
    cont_ev  = data_hit && (combined_mode || (stream_active && !brk_ev));
    start_ev = miss_ev || tgt_ev || cont_ev;
    stop_ev  = brk_ev && !start_ev;
  end
endmodule

// File: rtl/sb_l2_port.sv
module sb_l2_port #(
  parameter int TAG_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_ev,
  input  logic             cancel_ev,
  input  logic             pend,
  input  logic             req_ready,
  input  logic             rsp_valid,
  input  logic [TAG_W-1:0] rsp_tag,
  output logic             req_valid,
  output logic [TAG_W-1:0] req_tag,
  output logic             rsp_take
);
  logic [TAG_W-1:0] epoch;
  logic             issued;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      epoch  <= '0;
      issued <= 1'b0;
    end else if (start_ev || cancel_ev) begin
      epoch  <= epoch + TAG_W'(1);
      issued <= 1'b0;
    end else if (req_valid && req_ready) begin
      issued <= 1'b1;
    end
  end

  always_comb begin
    req_valid = pend && !issued;
    req_tag   = epoch;
    rsp_take  = rsp_valid && pend && issued && (rsp_tag == epoch)
                && !start_ev && !cancel_ev;
  end
endmodule

// File: rtl/sb_stream_buffer.sv
module sb_stream_buffer
  import sb_pkg::*;
#(
  parameter int ADDR_W     = 16,
  parameter int LINE_BYTES = 32,
  parameter int TAG_W      = 3
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    combined_mode,
  input  logic                    fetch_valid,
  input  logic [ADDR_W-1:0]       fetch_addr,
  input  logic                    fetch_branch,
  input  logic                    icache_hit,
  input  logic                    tgt_buf_hit,
  output logic                    fill_valid,
  output logic [ADDR_W-1:0]       fill_addr,
  output logic [LINE_BYTES*8-1:0] fill_data,
  output logic                    hit_pending,
  output logic                    l2_req_valid,
  input  logic                    l2_req_ready,
  output logic [ADDR_W-1:0]       l2_req_addr,
  output logic [TAG_W-1:0]        l2_req_tag,
  input  logic                    l2_rsp_valid,
  input  logic [TAG_W-1:0]        l2_rsp_tag,
  input  logic [LINE_BYTES*8-1:0] l2_rsp_data
);
  localparam int OFS_W  = $clog2(LINE_BYTES);
  localparam int LINE_W = LINE_BYTES * 8;

  sb_state_e           buf_state;
  logic [ADDR_W-1:0]   buf_line;
  logic [LINE_W-1:0]   buf_data;
  logic                stream_active;

  logic                line_match;
  logic                data_hit;
  logic                pend_hit;
  logic [ADDR_W-1:0]   seq_line;
  logic                miss_ev;
  logic                start_ev;
  logic                stop_ev;
  logic                cancel_ev;
  logic                rsp_take;

  sb_lookup #(.AW(ADDR_W), .OFS_W(OFS_W)) u_lookup (
    .fetch_valid (fetch_valid),
    .fetch_addr  (fetch_addr),
    .icache_hit  (icache_hit),
    .buf_state   (buf_state),
    .buf_line    (buf_line),
    .line_match  (line_match),
    .data_hit    (data_hit),
    .pend_hit    (pend_hit),
    .seq_line    (seq_line)
  );

  sb_trigger u_trigger (
    .combined_mode (combined_mode),
    .fetch_valid   (fetch_valid),
    .icache_hit    (icache_hit),
    .fetch_branch  (fetch_branch),
    .tgt_buf_hit   (tgt_buf_hit),
    .line_match    (line_match),
    .data_hit      (data_hit),
    .stream_active (stream_active),
    .miss_ev       (miss_ev),
    .start_ev      (start_ev),
    .stop_ev       (stop_ev)
  );

  assign cancel_ev = stop_ev && (buf_state == SB_PEND);

  sb_l2_port #(.TAG_W(TAG_W)) u_port (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ev  (start_ev),
    .cancel_ev (cancel_ev),
    .pend      (buf_state == SB_PEND),
    .req_ready (l2_req_ready),
    .rsp_valid (l2_rsp_valid),
    .rsp_tag   (l2_rsp_tag),
    .req_valid (l2_req_valid),
    .req_tag   (l2_req_tag),
    .rsp_take  (rsp_take)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_state     <= SB_EMPTY;
      buf_line      <= '0;
      buf_data      <= '0;
      stream_active <= 1'b0;
    end else if (start_ev) begin
      buf_state     <= SB_PEND;
      buf_line      <= seq_line;
      stream_active <= 1'b1;
    end else if (stop_ev) begin
      stream_active <= 1'b0;
      if (buf_state == SB_PEND) buf_state <= SB_EMPTY;
    end else if (rsp_take) begin
      buf_state <= SB_VALID;
      buf_data  <= l2_rsp_data;
    end
  end

  always_comb begin
    fill_valid  = data_hit;
    fill_addr   = buf_line;
    fill_data   = buf_data;
    hit_pending = pend_hit;
    l2_req_addr = buf_line;
  end
endmodule

// File: rtl/sb_stream_chk.sv
module sb_stream_chk #(
  parameter int AW    = 16,
  parameter int OFS_W = 5,
  parameter int TAG_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic [AW-1:0]    fetch_addr,
  input logic             fill_valid,
  input logic             hit_pending,
  input logic             l2_req_valid,
  input logic             l2_req_ready,
  input logic [AW-1:0]    l2_req_addr,
  input logic [TAG_W-1:0] l2_req_tag,
  input logic             l2_rsp_valid,
  input logic [TAG_W-1:0] l2_rsp_tag,
  input logic             start_ev,
  input logic             stop_ev,
  input logic [1:0]       buf_state
);
  localparam logic [AW-1:0] LOW_ONES = AW'((1 << OFS_W) - 1);
  logic [AW-1:0] exp_next;
  assign exp_next = (fetch_addr | LOW_ONES) + AW'(1);

  a_r1_quiet_after_reset: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (!l2_req_valid && !fill_valid && !hit_pending));

  a_r2_start_request: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (l2_req_valid && l2_req_addr == $past(exp_next)));

  a_r3_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (l2_req_valid && !l2_req_ready && !start_ev && !stop_ev)
      |=> (l2_req_valid && $stable(l2_req_addr) && $stable(l2_req_tag)));

  a_r5_fill_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(fill_valid && hit_pending));

  a_r7_stop_cancels: assert property (@(posedge clk) disable iff (!rst_n)
    stop_ev |=> !l2_req_valid);

  a_r9_new_tag: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> (l2_req_tag != $past(l2_req_tag)));

  a_r9_stale_dropped: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_state == 2'd1 && l2_rsp_valid && l2_rsp_tag != l2_req_tag && !start_ev && !stop_ev)
      |=> (buf_state == 2'd1));
endmodule

bind sb_stream_buffer sb_stream_chk #(.AW(ADDR_W), .OFS_W(OFS_W), .TAG_W(TAG_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_addr   (fetch_addr),
  .fill_valid   (fill_valid),
  .hit_pending  (hit_pending),
  .l2_req_valid (l2_req_valid),
  .l2_req_ready (l2_req_ready),
  .l2_req_addr  (l2_req_addr),
  .l2_req_tag   (l2_req_tag),
  .l2_rsp_valid (l2_rsp_valid),
  .l2_rsp_tag   (l2_rsp_tag),
  .start_ev     (start_ev),
  .stop_ev      (stop_ev),
  .buf_state    (buf_state)
);

// File: tb/tb_sb_stream_buffer.sv
module tb_sb_stream_buffer;
  localparam int AW = 16;
  localparam int TW = 3;
  localparam int LW = 256;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic          rst_n, combined_mode, fetch_valid, fetch_branch, icache_hit, tgt_buf_hit;
  logic [AW-1:0] fetch_addr;
  logic          fill_valid, hit_pending, l2_req_valid, l2_req_ready, l2_rsp_valid;
  logic [AW-1:0] fill_addr, l2_req_addr;
  logic [LW-1:0] fill_data, l2_rsp_data;
  logic [TW-1:0] l2_req_tag, l2_rsp_tag;

  sb_stream_buffer #(.ADDR_W(AW), .LINE_BYTES(32), .TAG_W(TW)) dut (
    .clk(clk), .rst_n(rst_n), .combined_mode(combined_mode),
    .fetch_valid(fetch_valid), .fetch_addr(fetch_addr), .fetch_branch(fetch_branch),
    .icache_hit(icache_hit), .tgt_buf_hit(tgt_buf_hit),
    .fill_valid(fill_valid), .fill_addr(fill_addr), .fill_data(fill_data),
    .hit_pending(hit_pending), .l2_req_valid(l2_req_valid), .l2_req_ready(l2_req_ready),
    .l2_req_addr(l2_req_addr), .l2_req_tag(l2_req_tag), .l2_rsp_valid(l2_rsp_valid),
    .l2_rsp_tag(l2_rsp_tag), .l2_rsp_data(l2_rsp_data)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  logic          cap_fill, cap_hpend;
  logic [AW-1:0] cap_faddr;
  logic [LW-1:0] cap_fdata;
  logic [TW-1:0] cap_tag, t0, t1;
  logic [AW-1:0] e;
  logic [LW-1:0] ed;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] a);
    return (a & 16'hFFE0) + 16'd32;
  endfunction

  function automatic logic [LW-1:0] ld(input logic [AW-1:0] a);
    return {8{{a ^ 16'h5A3C, a}}};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  // Starts at a negedge; samples combinational outputs, then ends at the next negedge.
  task automatic do_fetch(input logic [AW-1:0] a, input logic ih, input logic br, input logic tb);
    fetch_valid = 1; fetch_addr = a; icache_hit = ih; fetch_branch = br; tgt_buf_hit = tb;
    #1;
    cap_fill = fill_valid; cap_hpend = hit_pending; cap_faddr = fill_addr; cap_fdata = fill_data;
    @(negedge clk);
    fetch_valid = 0; icache_hit = 0; fetch_branch = 0; tgt_buf_hit = 0;
  endtask

  task automatic accept;
    l2_req_ready = 1;
    #1 cap_tag = l2_req_tag;
    @(negedge clk);
    l2_req_ready = 0;
  endtask

  task automatic respond(input logic [TW-1:0] tg, input logic [LW-1:0] d);
    l2_rsp_valid = 1; l2_rsp_tag = tg; l2_rsp_data = d;
    @(negedge clk);
    l2_rsp_valid = 0;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; combined_mode = 0; fetch_valid = 0; fetch_addr = '0; fetch_branch = 0;
    icache_hit = 0; tgt_buf_hit = 0; l2_req_ready = 0; l2_rsp_valid = 0; l2_rsp_tag = '0;
    l2_rsp_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(!l2_req_valid && !fill_valid && !hit_pending, "R1 reset idle", {61'd0, l2_req_valid, fill_valid, hit_pending}, 0);
    do_fetch(16'h0000, 1, 0, 0);
    chk(!cap_fill && !l2_req_valid, "R1 no fill/request after reset", {62'd0, cap_fill, l2_req_valid}, 0);

    // Sweep: start, hold, accept, respond, fill, advance.
    for (int i = 0; i < 12; i++) begin
      logic [AW-1:0] a;
      a = AW'(i * 16'h1234 + 16'h0011 + i);
      do_fetch(a, 0, 0, (i % 2) == 1);
      e = nxt(a);
      chk(l2_req_valid && l2_req_addr == e, "R2 request next line", {48'd0, l2_req_addr}, {48'd0, e});
      @(negedge clk);
      chk(l2_req_valid && l2_req_addr == e, "R3 request held", {48'd0, l2_req_addr}, {48'd0, e});
      accept();
      chk(!l2_req_valid, "R3 withdrawn after accept", {63'd0, l2_req_valid}, 0);
      ed = ld(e);
      respond(cap_tag, ed);
      do_fetch(e + 16'd5, 0, 0, 0);
      chk(cap_fill && cap_faddr == e, "R4 fill addr", {48'd0, cap_faddr}, {48'd0, e});
      chk(cap_fdata == ed, "R4 fill data", cap_fdata[63:0], ed[63:0]);
      chk(l2_req_valid && l2_req_addr == nxt(e), "R6 stream advances", {48'd0, l2_req_addr}, {48'd0, nxt(e)});
    end

    // Wrap at the top of the address space.
    do_fetch(16'hFFF3, 0, 0, 0);
    chk(l2_req_valid && l2_req_addr == 16'h0000, "R2 wrap", {48'd0, l2_req_addr}, 0);
    accept();
    ed = ld(16'h0000);
    respond(cap_tag, ed);
    do_fetch(16'h001F, 0, 0, 0);
    chk(cap_fill && cap_faddr == 16'h0000 && cap_fdata == ed, "R4 fill after wrap", {48'd0, cap_faddr}, 0);

    // Pending hit.
    do_fetch(16'h0024, 0, 0, 0);
    chk(cap_hpend && !cap_fill, "R5 pending hit flags", {62'd0, cap_hpend, cap_fill}, 2);
    chk(l2_req_valid && l2_req_addr == 16'h0020, "R5 request unchanged", {48'd0, l2_req_addr}, 16'h0020);

    // Cancel and stale response.
    accept(); t0 = cap_tag;
    do_fetch(16'h3000, 0, 0, 0);
    chk(l2_req_valid && l2_req_addr == 16'h3020 && l2_req_tag != t0, "R9 new request new tag", {45'd0, l2_req_tag, l2_req_addr}, {45'd0, t0, 16'h3020});
    accept(); t1 = cap_tag;
    respond(t0, ld(16'h0020));
    do_fetch(16'h3021, 0, 0, 0);
    chk(cap_hpend && !cap_fill, "R9 stale response ignored", {62'd0, cap_hpend, cap_fill}, 2);
    ed = ld(16'h3020);
    respond(t1, ed);
    do_fetch(16'h3030, 0, 0, 0);
    chk(cap_fill && cap_fdata == ed, "R9 own response taken", cap_fdata[63:0], ed[63:0]);

    // Branch stop with awaited line.
    do_fetch(16'h7000, 1, 1, 0);
    chk(!l2_req_valid, "R7 branch cancels request", {63'd0, l2_req_valid}, 0);
    do_fetch(16'h3040, 0, 0, 0);
    chk(!cap_hpend && !cap_fill, "R7 cancelled line not pending", {62'd0, cap_hpend, cap_fill}, 0);
    accept();
    ed = ld(16'h3060);
    respond(cap_tag, ed);
    do_fetch(16'h5000, 1, 1, 0);
    chk(!l2_req_valid, "R7 no request after stop", {63'd0, l2_req_valid}, 0);
    do_fetch(16'h3064, 0, 0, 0);
    chk(cap_fill && cap_fdata == ed, "R7 valid line kept", cap_fdata[63:0], ed[63:0]);
    chk(!l2_req_valid, "R7 stopped stream does not advance", {63'd0, l2_req_valid}, 0);

    // Ignored stimuli in normal mode.
    do_fetch(16'h4444, 1, 0, 1);
    chk(!cap_fill && !l2_req_valid, "R10 icache hit with companion hit ignored", {62'd0, cap_fill, l2_req_valid}, 0);
    do_fetch(16'h3070, 1, 0, 0);
    chk(!cap_fill && !l2_req_valid, "R10 icache hit in buffer line", {62'd0, cap_fill, l2_req_valid}, 0);
    do_fetch(16'h3068, 0, 0, 0);
    chk(cap_fill && cap_fdata == ed && !l2_req_valid, "R10 buffer untouched", cap_fdata[63:0], ed[63:0]);

    // Combined mode.
    combined_mode = 1;
    do_fetch(16'h3064, 0, 0, 0);
    chk(cap_fill && l2_req_valid && l2_req_addr == 16'h3080, "R8 buffer hit retriggers", {48'd0, l2_req_addr}, 16'h3080);
    do_fetch(16'h9000, 0, 0, 1);
    chk(l2_req_valid && l2_req_addr == 16'h9020, "R8 companion hit triggers", {48'd0, l2_req_addr}, 16'h9020);

    // Miss and branch together.
    combined_mode = 0;
    do_fetch(16'hA010, 0, 1, 0);
    chk(l2_req_valid && l2_req_addr == 16'hA020, "R11 miss beats branch", {48'd0, l2_req_addr}, 16'hA020);

    finish_run();
  end
endmodule